// File: doc/BRIEF.md
# Last Branch Record Stack

This block keeps a short history of control transfers for debug. Each time a taken branch, an interrupt or an exception is reported on the event inputs, the block can store the source and destination linear addresses as one entry of a four-slot circular stack. The newest entry always sits at the top-of-stack pointer. Once four entries are held, each new one overwrites the oldest.

Two software flags gate capture. The record flag is the usual switch. The trace flag also keeps capture running when the record flag is clear, because an external trace generator builds its messages from the same entries. When a debug exception is reported, the hardware clears the record flag on its own and leaves the trace flag and every stored entry alone. A debugger can then read back the last four transfers that led to the fault. Capture resumes only after software sets the record flag again, unless tracing is still active. Whenever an entry is written while the trace flag is set, the block sends a one-cycle strobe that carries that entry.

Top module: `branch_history_stack`

## Requirements
- R1: Reset clears the record flag, the trace flag, the 2-bit top-of-stack pointer, all four entries and the trace strobe to zero.
- R2: While the record flag is set, a valid event of kind 0 (taken branch), 1 (interrupt) or 2 (exception) first advances the pointer by one, modulo 4. It then writes its source and destination into the slot the new pointer names. Both changes are visible on the ports one cycle after the event.
- R3: A valid event of kind 3 (debug exception) never writes an entry and never moves the pointer.
- R4: A valid debug exception clears the record flag in the following cycle and leaves the trace flag as it was.
- R5: Clearing the record flag, whether software or a debug exception does it, leaves every stored entry unchanged.
- R6: The stack holds the four most recent captured events. The fifth capture after reset reuses the slot of the first.
- R7: While the trace flag is set, events of kinds 0 to 2 are captured even if the record flag is clear.
- R8: With both flags clear, no event changes the pointer or any entry.
- R9: A software flag write loads both flags one cycle later. If a debug exception arrives in the same cycle, the record flag ends up clear, while the trace flag takes the written value.
- R10: The trace strobe is high for exactly the cycle after a capture that happened while the trace flag was set. In that cycle it carries the captured source and destination. It is low at all other times.
- R11: After a debug exception with the trace flag clear, no capture happens until software sets the record flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 2 | Event kind: 0 branch, 1 interrupt, 2 exception, 3 debug exception |
| ev_src | input | ADDR_W | Source linear address of the event |
| ev_dst | input | ADDR_W | Destination linear address of the event |
| cfg_wr | input | 1 | Software write strobe for the flags |
| cfg_rec | input | 1 | Record flag value to write |
| cfg_trace | input | 1 | Trace flag value to write |
| rd_idx | input | 2 | Slot selected for software read |
| rd_src | output | ADDR_W | Source address held in the selected slot |
| rd_dst | output | ADDR_W | Destination address held in the selected slot |
| rec_en_o | output | 1 | Current record flag |
| trace_en_o | output | 1 | Current trace flag |
| tos_o | output | 2 | Top-of-stack pointer |
| trace_vld | output | 1 | One-cycle strobe for an entry written while tracing |
| trace_src | output | ADDR_W | Source address of the traced entry |
| trace_dst | output | ADDR_W | Destination address of the traced entry |

## Verification
The bench aims at the moments when the flags and the stack interact. One is a debug exception arriving while only tracing is on: a design that also cleared the trace flag, or that stopped capturing, would leave a stale pointer. Another is a flag write that lands in the same cycle as a debug exception: a design with the priority backwards would come out with the record flag set. The bench also checks that the pointer wraps on the fifth capture and that entries survive the record flag being cleared. A design that wrote before it advanced, or that flushed the stack on a clear, would show the wrong slot contents on read-back. Random event streams with occasional flag writes are compared, cycle by cycle, against a bench model of the flags, the pointer, all four slots and the strobe.

// File: rtl/bhs_pkg.sv
package bhs_pkg;
  typedef enum logic [1:0] {
    EV_BRANCH = 2'd0,
    EV_IRQ    = 2'd1,
    EV_EXC    = 2'd2,
    EV_DBG    = 2'd3
  } ev_kind_e;

  // Kinds that may be captured into the stack
  function automatic logic kind_recordable(input logic [1:0] kind);
    return kind != EV_DBG;
  endfunction

  function automatic logic kind_is_debug(input logic [1:0] kind);
    return kind == EV_DBG;
  endfunction
endpackage

// File: rtl/bhs_ctrl.sv
module bhs_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_rec,
  input  logic cfg_trace,
  input  logic dbg_hit,
  output logic rec_en,
  output logic trace_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_en   <= 1'b0;
      trace_en <= 1'b0;
    end else begin
      if (cfg_wr) begin
        rec_en   <= cfg_rec;
        trace_en <= cfg_trace;
      end
      // hardware clear wins over a same-cycle software write
      if (dbg_hit) rec_en <= 1'b0;
    end
  end
endmodule

// File: rtl/bhs_ptr.sv
module bhs_ptr #(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] tos,
  output logic [PTR_W-1:0] wr_slot
);
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  assign wr_slot = ptr_next(tos);

  always_ff @(posedge clk) begin
    if (!rst_n)   tos <= '0;
    else if (adv) tos <= wr_slot;
  end
endmodule

// File: rtl/bhs_store.sv
module bhs_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_slot,
  input  logic [ADDR_W-1:0] wr_src,
  input  logic [ADDR_W-1:0] wr_dst,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst
);
  logic [DEPTH-1:0][ADDR_W-1:0] src_q;
  logic [DEPTH-1:0][ADDR_W-1:0] dst_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q[g] <= '0;
        dst_q[g] <= '0;
      end else if (hit) begin
        src_q[g] <= wr_src;
        dst_q[g] <= wr_dst;
      end
    end
  end

  assign rd_src = src_q[rd_idx];
  assign rd_dst = dst_q[rd_idx];
endmodule

// File: rtl/branch_history_stack.sv
module branch_history_stack #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [ADDR_W-1:0] ev_src,
  input  logic [ADDR_W-1:0] ev_dst,
  input  logic              cfg_wr,
  input  logic              cfg_rec,
  input  logic              cfg_trace,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic              rec_en_o,
  output logic              trace_en_o,
  output logic [PTR_W-1:0]  tos_o,
  output logic              trace_vld,
  output logic [ADDR_W-1:0] trace_src,
  output logic [ADDR_W-1:0] trace_dst
);
  import bhs_pkg::*;

  // Named internal events for the checker
  logic dbg_hit;
  logic capture;
  logic [PTR_W-1:0] wr_slot;

  assign dbg_hit = ev_valid && kind_is_debug(ev_kind);
  assign capture = ev_valid && kind_recordable(ev_kind) && (rec_en_o || trace_en_o);

  bhs_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_rec  (cfg_rec),
    .cfg_trace(cfg_trace),
    .dbg_hit  (dbg_hit),
    .rec_en   (rec_en_o),
    .trace_en (trace_en_o)
  );

  bhs_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (capture),
    .tos    (tos_o),
    .wr_slot(wr_slot)
  );

  bhs_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (capture),
    .wr_slot(wr_slot),
    .wr_src (ev_src),
    .wr_dst (ev_dst),
    .rd_idx (rd_idx),
    .rd_src (rd_src),
    .rd_dst (rd_dst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trace_vld <= 1'b0;
      trace_src <= '0;
      trace_dst <= '0;
    end else begin
      trace_vld <= capture && trace_en_o;
      if (capture && trace_en_o) begin
        trace_src <= ev_src;
        trace_dst <= ev_dst;
      end
    end
  end
endmodule

// File: rtl/bhs_checker.sv
module bhs_checker #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic [1:0]        ev_kind,
  input logic              cfg_wr,
  input logic              capture,
  input logic              rec_en_o,
  input logic              trace_en_o,
  input logic [PTR_W-1:0]  tos_o,
  input logic              trace_vld,
  input logic [PTR_W-1:0]  rd_idx,
  input logic [ADDR_W-1:0] rd_src,
  input logic [ADDR_W-1:0] rd_dst
);
  logic dbg_ev;
  assign dbg_ev = ev_valid && (ev_kind == 2'd3);

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> tos_o == $past(tos_o) + PTR_W'(1));

  p_dbg_no_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ev |=> $stable(tos_o));

  p_dbg_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ev && !cfg_wr) |=> (!rec_en_o && $stable(trace_en_o)));

  p_entry_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(rd_idx) -> ($stable(rd_src) && $stable(rd_dst))));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_en_o && !trace_en_o) |=> $stable(tos_o));

  p_wr_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ev && cfg_wr) |=> !rec_en_o);

  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trace_vld |-> $past(ev_valid && (ev_kind != 2'd3) && trace_en_o));
endmodule

bind branch_history_stack bhs_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_valid  (ev_valid),
  .ev_kind   (ev_kind),
  .cfg_wr    (cfg_wr),
  .capture   (capture),
  .rec_en_o  (rec_en_o),
  .trace_en_o(trace_en_o),
  .tos_o     (tos_o),
  .trace_vld (trace_vld),
  .rd_idx    (rd_idx),
  .rd_src    (rd_src),
  .rd_dst    (rd_dst)
);

// File: tb/tb_branch_history_stack.sv
`timescale 1ns/1ps
module tb_branch_history_stack;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_kind = 2'd0;
  logic [AW-1:0] ev_src = '0, ev_dst = '0;
  logic cfg_wr = 1'b0, cfg_rec = 1'b0, cfg_trace = 1'b0;
  logic [1:0] rd_idx = 2'd0;
  logic [AW-1:0] rd_src, rd_dst, trace_src, trace_dst;
  logic rec_en_o, trace_en_o, trace_vld;
  logic [1:0] tos_o;

  always #10 clk = ~clk;

  branch_history_stack #(.ADDR_W(AW)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [AW-1:0] m_src [4];
  logic [AW-1:0] m_dst [4];
  logic [1:0] m_tos;
  logic m_rec, m_tr, m_vld;
  logic [AW-1:0] m_tsrc, m_tdst;

  function automatic logic [1:0] wrap_inc(input logic [1:0] p);
    return 2'((int'(p) + 1) % 4);
  endfunction

  function automatic bit will_capture(input logic v, input logic [1:0] k,
                                      input logic rec, input logic tr);
    return v && (k != 2'd3) && (rec || tr);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_src[i] = '0; m_dst[i] = '0; end
    m_tos = 0; m_rec = 0; m_tr = 0; m_vld = 0; m_tsrc = '0; m_tdst = '0;
  endtask

  task automatic check_slots(input string req);
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #1;
      check({req, " slot src"}, rd_src, m_src[i]);
      check({req, " slot dst"}, rd_dst, m_dst[i]);
    end
  endtask

  // One cycle: drive at negedge, model updates at the edge, check at the next negedge
  task automatic step(input logic v, input logic [1:0] k, input logic [AW-1:0] s,
                      input logic [AW-1:0] d, input logic w, input logic r,
                      input logic t, input string req);
    bit cap;
    ev_valid = v; ev_kind = k; ev_src = s; ev_dst = d;
    cfg_wr = w; cfg_rec = r; cfg_trace = t;
    cap = will_capture(v, k, m_rec, m_tr);
    m_vld = cap && m_tr;
    if (m_vld) begin m_tsrc = s; m_tdst = d; end
    if (cap) begin
      m_tos = wrap_inc(m_tos);
      m_src[m_tos] = s; m_dst[m_tos] = d;
    end
    if (w) begin m_rec = r; m_tr = t; end
    if (v && k == 2'd3) m_rec = 0;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 0; cfg_wr = 0;
    check({req, " rec flag"}, rec_en_o, m_rec);
    check({req, " trace flag"}, trace_en_o, m_tr);
    check({req, " tos"}, tos_o, m_tos);
    check({req, " strobe"}, trace_vld, m_vld);
    if (m_vld) begin
      check({req, " strobe src"}, trace_src, m_tsrc);
      check({req, " strobe dst"}, trace_dst, m_tdst);
    end
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 rec", rec_en_o, 0);
    check("R1 trace", trace_en_o, 0);
    check("R1 tos", tos_o, 0);
    check("R1 strobe", trace_vld, 0);
    check_slots("R1");

    // R8 both flags clear: nothing captured
    step(1, 2'd0, 32'h1111, 32'h2222, 0, 0, 0, "R8");
    check_slots("R8");

    // R2 / R6 record flag on, five captures wrap
    step(0, 0, 0, 0, 1, 1, 0, "R9 write");
    for (int i = 0; i < 5; i++)
      step(1, 2'(i % 3), 32'hA000 + 32'(i), 32'hB000 + 32'(i), 0, 0, 0, "R2 R6");
    check("R6 tos after five", tos_o, 2'd1);
    check_slots("R6");

    // R3 / R4 / R5 debug exception
    step(1, 2'd3, 32'hDEAD, 32'hBEEF, 0, 0, 0, "R3 R4");
    check_slots("R5");
    // R11 no capture until re-enabled
    step(1, 2'd0, 32'hC0, 32'hC1, 0, 0, 0, "R11");
    step(1, 2'd1, 32'hC2, 32'hC3, 0, 0, 0, "R11");
    check_slots("R11");
    step(0, 0, 0, 0, 1, 1, 0, "R11 resume");
    step(1, 2'd2, 32'hC4, 32'hC5, 0, 0, 0, "R11 resume");
    // R5 software clear keeps entries
    step(0, 0, 0, 0, 1, 0, 0, "R5 sw clear");
    check_slots("R5 sw");

    // R7 / R10 trace only, debug exception keeps tracing
    step(0, 0, 0, 0, 1, 0, 1, "R7 write");
    step(1, 2'd0, 32'hE0, 32'hE1, 0, 0, 0, "R7 R10");
    step(1, 2'd3, 32'hE2, 32'hE3, 0, 0, 0, "R4 trace kept");
    step(1, 2'd1, 32'hE4, 32'hE5, 0, 0, 0, "R7 after dbg");
    // R9 same-cycle write and debug exception
    step(1, 2'd3, 32'hF0, 32'hF1, 1, 1, 1, "R9 prio");
    check_slots("R7");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic v, w;
      logic [1:0] k;
      v = ($urandom % 4) != 0;
      k = 2'($urandom % 4);
      w = ($urandom % 7) == 0;
      step(v, k, $urandom, $urandom, w, 1'($urandom), 1'($urandom), "R2 R10 random");
      if (n % 8 == 0) check_slots("R5 random");
    end
    check_slots("R6 final");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule